// File: doc/BRIEF.md
# Segmented Address Translation Sequencer

This block orders the checks that turn a 32-bit effective address into a real address, or into a fault with a syndrome word. One request is taken at a time through a valid/ready pair. It carries the effective address, the access type, a data sub-kind, a real-mode flag and a user (unprivileged) flag. The block holds sixteen segment registers, written through a plain write port. It drives two external helpers through request/response pairs: a block-translation matcher and a page-table walker. It returns one result per request on a valid/ready output.

A real-mode request completes at once. Any other request is first offered to the matcher. On a miss, the segment register chosen by the top address nibble decides the next step: the direct-store path, a no-execute fault, or a page-table walk. A walk result goes through the key/page-protection table. Back-pressure rules: `req_ready` is high only while the sequencer is idle. A response, once raised, holds `rsp_valid` and every result field steady until `rsp_ready` is sampled high. The helper requests stay high until their one-cycle response pulse arrives.

Top module: `xlate_seq`

## Requirements
- R1: A request with `req_real` set completes with status OK, `rsp_raddr` equal to the effective address and permission 3'b111. The response is valid in the cycle after acceptance, and neither helper is requested.
- R2: Every other request first raises `bat_req_valid` with the address, fetch flag and user flag, and holds it until `bat_rsp_valid`. On a hit whose permission covers the access, the result is the matcher's address and permission. On a hit that does not cover it, the result is a protection fault (R6 codes).
- R3: After a matcher miss, the segment register is selected by EA[31:28]. Its layout is: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 23:0 segment id. A write on `sr_we` takes effect from the next cycle.
- R4: A fetch that reaches a direct-store segment or a no-execute segment gives an instruction fault with syndrome 0x10000000, and no walk is started.
- R5: When the walker reports not found, a fetch gives an instruction fault with 0x40000000. A store gives a data fault with 0x42000000, and a load gives a data fault with 0x40000000.
- R6: The key is the segment's user key bit for user requests and its supervisor key bit otherwise. Page field PP grants: 0 gives rwx with key 0 and nothing with key 1; 1 gives rwx with key 0 and r-x with key 1; 2 gives rwx; 3 gives r-x. The execute right is removed in a no-execute segment. A violation gives 0x08000000 as an instruction fault for a fetch. For data accesses it gives a data fault with 0x0A000000 for a store and 0x08000000 for a load.
- R7: A permitted walk result has the real address {`walk_rpn`, EA[11:0]} and the granted permission.
- R8: On a direct-store segment, the data sub-kind decides the outcome. Integer (0) is checked by R9 with the identity address. Cache-op (3) completes OK with the identity address. Floating (1) gives an alignment fault with syndrome 0. Reservation (2) gives a data fault with 0x06000000 for a store and 0x04000000 for a load. External (4) gives a data fault with 0x06100000 for a store and 0x04100000 for a load.
- R9: On the direct-store path, a key of 1 grants read-write (3'b011) and a key of 0 grants read-only (3'b001). An integer store with key 0 is a protection fault with 0x0A000000.
- R10: Data faults and alignment faults report the effective address in `rsp_fault_addr`. Instruction faults and OK results report 0 there.
- R11: `rsp_valid` and all response fields stay unchanged while `rsp_ready` is low. `req_ready` is high only when no request is in flight.
- R12: The encodings are as follows. Access type: 0 fetch, 1 load, 2 store. Status: 0 OK, 1 instruction fault, 2 data fault, 3 alignment fault. Permission bits: [0] read, [1] write, [2] execute. Any fault reports permission 0 and real address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type (0 fetch, 1 load, 2 store) |
| req_kind | input | 3 | Data sub-kind (0 int, 1 float, 2 reservation, 3 cache-op, 4 external) |
| req_real | input | 1 | Translation off |
| req_user | input | 1 | Unprivileged request |
| sr_we | input | 1 | Segment register write strobe |
| sr_widx | input | 4 | Segment register index |
| sr_wdata | input | 32 | Segment register value |
| bat_req_valid | output | 1 | Matcher request, held until response |
| bat_ea | output | 32 | Address for the matcher |
| bat_fetch | output | 1 | Request is a fetch |
| bat_user | output | 1 | Request is unprivileged |
| bat_rsp_valid | input | 1 | Matcher response pulse |
| bat_hit | input | 1 | Matcher hit |
| bat_raddr | input | 32 | Matcher real address |
| bat_perm | input | 3 | Matcher permission |
| walk_req_valid | output | 1 | Walker request, held until response |
| walk_vsid | output | 24 | Segment id for the hash |
| walk_ea | output | 32 | Address for the walker |
| walk_rsp_valid | input | 1 | Walker response pulse |
| walk_found | input | 1 | Page entry found |
| walk_rpn | input | 20 | Page number field of the entry's second word |
| walk_pp | input | 2 | Page protection field of the entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_status | output | 2 | Result status |
| rsp_raddr | output | 32 | Real address |
| rsp_perm | output | 3 | Granted permission |
| rsp_syndrome | output | 32 | Fault syndrome |
| rsp_fault_addr | output | 32 | Fault address |

## Verification
A real-mode result is due one cycle after acceptance. Otherwise the result is due one cycle after the last helper pulse: the matcher pulse when the block ends at the matcher or segment stage, and the walker pulse after a walk. Each helper request must appear in the cycle after the previous stage finishes and stay high across the helper latency. The bench plays both helpers with a latency chosen per vector. In every cycle between handshakes it compares request, response and ready levels against the cycle its own model predicts, sampling on the falling edge. After each result it withholds `rsp_ready` for one cycle to confirm that the fields hold steady.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int EA_W     = 32;
  localparam int NSEG     = 16;
  localparam int SEL_W    = $clog2(NSEG);
  localparam int VSID_W   = 24;
  localparam int PAGE_B   = 12;
  localparam int RPN_W    = EA_W - PAGE_B;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [2:0] DK_INT   = 3'd0;
  localparam logic [2:0] DK_FLOAT = 3'd1;
  localparam logic [2:0] DK_RESV  = 3'd2;
  localparam logic [2:0] DK_CACHE = 3'd3;
  localparam logic [2:0] DK_EXT   = 3'd4;

  typedef enum logic [1:0] {ST_OK = 2'd0, ST_IFAULT = 2'd1,
                            ST_DFAULT = 2'd2, ST_ALIGN = 2'd3} status_e;

  typedef enum logic [2:0] {CZ_NONE, CZ_NOEXEC, CZ_MISS, CZ_PROT,
                            CZ_RESV, CZ_EXT, CZ_ALIGN} cause_e;

  typedef struct packed {
    logic              dstore;
    logic              key_sup;
    logic              key_usr;
    logic              noexec;
    logic [VSID_W-1:0] vsid;
  } seg_t;

  function automatic logic perm_covers(input logic [2:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return perm[2];
      ACC_STORE: return perm[1];
      default:   return perm[0];
    endcase
  endfunction
endpackage

// File: rtl/xlate_segfile.sv
module xlate_segfile
  import xlate_pkg::*;
#(
  parameter int N  = NSEG,
  parameter int W  = EA_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output seg_t          rdata
);
  seg_t regs [N];
  seg_t wseg;
  logic unused_bits;

  assign wseg = '{dstore: wdata[W-1], key_sup: wdata[W-2], key_usr: wdata[W-3],
                  noexec: wdata[W-4], vsid: wdata[VSID_W-1:0]};
  assign unused_bits = ^wdata[W-5:VSID_W];

  for (genvar g = 0; g < N; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && widx == IW'(g))       regs[g] <= wseg;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic       key,
  input  logic       dstore,
  input  logic       noexec,
  input  logic [1:0] pp,
  output logic [2:0] perm
);
  logic [2:0] page;
  always_comb begin
    case (pp)
      2'd0:    page = key ? 3'b000 : 3'b111;
      2'd1:    page = key ? 3'b101 : 3'b111;
      2'd2:    page = 3'b111;
      default: page = 3'b101;
    endcase
    if (noexec) page[2] = 1'b0;
    perm = dstore ? (key ? 3'b011 : 3'b001) : page;
  end
endmodule

// File: rtl/xlate_syndrome.sv
module xlate_syndrome
  import xlate_pkg::*;
(
  input  cause_e      cause,
  input  logic [1:0]  acc,
  output status_e     status,
  output logic [31:0] syn
);
  logic fetch, store;
  assign fetch = (acc == ACC_FETCH);
  assign store = (acc == ACC_STORE);

  always_comb begin
    status = ST_OK;
    syn    = '0;
    case (cause)
      CZ_NOEXEC: begin status = ST_IFAULT; syn = 32'h1000_0000; end
      CZ_MISS: begin
        status = fetch ? ST_IFAULT : ST_DFAULT;
        syn    = store ? 32'h4200_0000 : 32'h4000_0000;
      end
      CZ_PROT: begin
        status = fetch ? ST_IFAULT : ST_DFAULT;
        syn    = store ? 32'h0A00_0000 : 32'h0800_0000;
      end
      CZ_RESV: begin status = ST_DFAULT; syn = store ? 32'h0600_0000 : 32'h0400_0000; end
      CZ_EXT:  begin status = ST_DFAULT; syn = store ? 32'h0610_0000 : 32'h0410_0000; end
      CZ_ALIGN: status = ST_ALIGN;
      default: ;
    endcase
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_acc,
  input  logic [2:0]        req_kind,
  input  logic              req_real,
  input  logic              req_user,
  input  logic              sr_we,
  input  logic [SEL_W-1:0]  sr_widx,
  input  logic [EA_W-1:0]   sr_wdata,
  output logic              bat_req_valid,
  output logic [EA_W-1:0]   bat_ea,
  output logic              bat_fetch,
  output logic              bat_user,
  input  logic              bat_rsp_valid,
  input  logic              bat_hit,
  input  logic [EA_W-1:0]   bat_raddr,
  input  logic [2:0]        bat_perm,
  output logic              walk_req_valid,
  output logic [VSID_W-1:0] walk_vsid,
  output logic [EA_W-1:0]   walk_ea,
  input  logic              walk_rsp_valid,
  input  logic              walk_found,
  input  logic [RPN_W-1:0]  walk_rpn,
  input  logic [1:0]        walk_pp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [EA_W-1:0]   rsp_raddr,
  output logic [2:0]        rsp_perm,
  output logic [31:0]       rsp_syndrome,
  output logic [EA_W-1:0]   rsp_fault_addr
);
  typedef enum logic [1:0] {S_IDLE, S_BLK, S_WALK, S_DONE} state_e;
  state_e state;

  logic [EA_W-1:0] ea_q;
  logic [1:0]      acc_q;
  logic [2:0]      kind_q;
  logic            user_q;

  seg_t       seg;
  logic       key;
  logic [2:0] seg_perm;
  logic [2:0] page_perm;

  xlate_segfile #(.N(NSEG), .W(EA_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .we(sr_we), .widx(sr_widx), .wdata(sr_wdata),
    .ridx(ea_q[EA_W-1 -: SEL_W]), .rdata(seg));

  assign key = user_q ? seg.key_usr : seg.key_sup;

  xlate_perm u_dsperm (.key(key), .dstore(1'b1), .noexec(seg.noexec),
                       .pp(2'd0), .perm(seg_perm));
  xlate_perm u_pgperm (.key(key), .dstore(1'b0), .noexec(seg.noexec),
                       .pp(walk_pp), .perm(page_perm));

  // next-result decision
  logic            fin;
  logic            go_walk;
  cause_e          d_cause;
  logic [EA_W-1:0] d_raddr;
  logic [2:0]      d_perm;
  logic [1:0]      acc_sel;
  status_e         d_status;
  logic [31:0]     d_syn;

  assign acc_sel = (state == S_IDLE) ? req_acc : acc_q;

  always_comb begin
    fin     = 1'b0;
    go_walk = 1'b0;
    d_cause = CZ_NONE;
    d_raddr = ea_q;
    d_perm  = 3'b000;
    case (state)
      S_IDLE: if (req_valid && req_real) begin
        fin     = 1'b1;
        d_raddr = req_ea;
        d_perm  = 3'b111;
      end
      S_BLK: if (bat_rsp_valid) begin
        fin = 1'b1;
        if (bat_hit) begin
          d_raddr = bat_raddr;
          d_perm  = bat_perm;
          if (!perm_covers(bat_perm, acc_q)) d_cause = CZ_PROT;
        end else if (seg.dstore) begin
          d_perm = seg_perm;
          if (acc_q == ACC_FETCH) d_cause = CZ_NOEXEC;
          else begin
            case (kind_q)
              DK_INT:   if (!perm_covers(seg_perm, acc_q)) d_cause = CZ_PROT;
              DK_CACHE: d_cause = CZ_NONE;
              DK_FLOAT: d_cause = CZ_ALIGN;
              DK_RESV:  d_cause = CZ_RESV;
              default:  d_cause = CZ_EXT;
            endcase
          end
        end else if (seg.noexec && acc_q == ACC_FETCH) begin
          d_cause = CZ_NOEXEC;
        end else begin
          fin     = 1'b0;
          go_walk = 1'b1;
        end
      end
      S_WALK: if (walk_rsp_valid) begin
        fin     = 1'b1;
        d_raddr = {walk_rpn, ea_q[PAGE_B-1:0]};
        d_perm  = page_perm;
        if (!walk_found)                        d_cause = CZ_MISS;
        else if (!perm_covers(page_perm, acc_q)) d_cause = CZ_PROT;
      end
      default: ;
    endcase
  end

  xlate_syndrome u_syn (.cause(d_cause), .acc(acc_sel), .status(d_status), .syn(d_syn));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      ea_q           <= '0;
      acc_q          <= '0;
      kind_q         <= '0;
      user_q         <= 1'b0;
      rsp_status     <= '0;
      rsp_raddr      <= '0;
      rsp_perm       <= '0;
      rsp_syndrome   <= '0;
      rsp_fault_addr <= '0;
    end else begin
      if (state == S_IDLE && req_valid) begin
        ea_q   <= req_ea;
        acc_q  <= req_acc;
        kind_q <= req_kind;
        user_q <= req_user;
      end
      if (fin) begin
        rsp_status     <= d_status;
        rsp_syndrome   <= d_syn;
        rsp_raddr      <= (d_status == ST_OK) ? d_raddr : '0;
        rsp_perm       <= (d_status == ST_OK) ? d_perm  : '0;
        rsp_fault_addr <= (d_status == ST_DFAULT || d_status == ST_ALIGN) ? ea_q : '0;
      end
      case (state)
        S_IDLE: if (req_valid) state <= req_real ? S_DONE : S_BLK;
        S_BLK:  if (fin) state <= S_DONE; else if (go_walk) state <= S_WALK;
        S_WALK: if (fin) state <= S_DONE;
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == S_IDLE);
  assign rsp_valid      = (state == S_DONE);
  assign bat_req_valid  = (state == S_BLK);
  assign bat_ea         = ea_q;
  assign bat_fetch      = (acc_q == ACC_FETCH);
  assign bat_user       = user_q;
  assign walk_req_valid = (state == S_WALK);
  assign walk_vsid      = seg.vsid;
  assign walk_ea        = ea_q;
endmodule

// File: rtl/xlate_seq_chk.sv
module xlate_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_ea,
  input logic        req_real,
  input logic        bat_req_valid,
  input logic        bat_rsp_valid,
  input logic        walk_req_valid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_raddr,
  input logic [2:0]  rsp_perm,
  input logic [31:0] rsp_syndrome,
  input logic [31:0] rsp_fault_addr
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_raddr)
      && $stable(rsp_perm) && $stable(rsp_syndrome) && $stable(rsp_fault_addr));

  a_r11_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !bat_req_valid && !walk_req_valid);

  a_r1_real_pass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_real |=> rsp_valid && rsp_status == 2'd0
      && rsp_perm == 3'b111 && rsp_raddr == $past(req_ea));

  a_r2_blk_held: assert property (@(posedge clk) disable iff (!rst_n)
    bat_req_valid && !bat_rsp_valid |=> bat_req_valid);

  a_r4_walk_after_blk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req_valid) |-> $past(bat_req_valid));

  a_r12_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd0 |-> rsp_perm == 3'b000 && rsp_raddr == 32'd0);

  a_r10_ifault_noaddr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 2'd1 |-> rsp_fault_addr == 32'd0);
endmodule

bind xlate_seq xlate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ea(req_ea), .req_real(req_real), .bat_req_valid(bat_req_valid),
  .bat_rsp_valid(bat_rsp_valid), .walk_req_valid(walk_req_valid),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm), .rsp_syndrome(rsp_syndrome),
  .rsp_fault_addr(rsp_fault_addr));

// File: tb/sim_xlate_seq.sv
module sim_xlate_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [31:0] req_ea = 0;
  logic [1:0]  req_acc = 0;
  logic [2:0]  req_kind = 0;
  logic        req_real = 0, req_user = 0;
  logic        sr_we = 0;
  logic [3:0]  sr_widx = 0;
  logic [31:0] sr_wdata = 0;
  logic        bat_req_valid, bat_fetch, bat_user;
  logic [31:0] bat_ea;
  logic        bat_rsp_valid = 0, bat_hit = 0;
  logic [31:0] bat_raddr = 0;
  logic [2:0]  bat_perm = 0;
  logic        walk_req_valid;
  logic [23:0] walk_vsid;
  logic [31:0] walk_ea;
  logic        walk_rsp_valid = 0, walk_found = 0;
  logic [19:0] walk_rpn = 0;
  logic [1:0]  walk_pp = 0;
  logic        rsp_valid, rsp_ready = 0;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_raddr, rsp_syndrome, rsp_fault_addr;
  logic [2:0]  rsp_perm;

  xlate_seq u0 (.*);

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [31:0] sr_m [16];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr_sr(int idx, logic [31:0] v);
    @(negedge clk);
    sr_we = 1; sr_widx = 4'(idx); sr_wdata = v;
    @(negedge clk);
    sr_we = 0;
    sr_m[idx] = v;
  endtask

  // behavioural expectation
  task automatic model(input logic [31:0] ea, input logic [1:0] acc, input logic [2:0] dk,
                       input bit rl, input bit us, input bit bh, input logic [31:0] bra,
                       input logic [2:0] bpm, input bit wf, input logic [19:0] rpn,
                       input logic [1:0] pp, output bit walk, output logic [1:0] st,
                       output logic [31:0] ra, output logic [2:0] pm,
                       output logic [31:0] sy, output logic [31:0] fa);
    logic [31:0] s;
    bit k, ok, prot;
    logic [2:0] p;
    s = sr_m[ea[31:28]];
    k = us ? s[29] : s[30];
    walk = 0; st = 0; ra = 0; pm = 0; sy = 0; prot = 0;
    if (rl) begin ra = ea; pm = 3'b111; end
    else if (bh) begin
      ok = (acc == 0) ? bpm[2] : (acc == 2) ? bpm[1] : bpm[0];
      if (ok) begin ra = bra; pm = bpm; end else prot = 1;
    end else if (s[31]) begin
      if (acc == 0) begin st = 1; sy = 32'h1000_0000; end
      else if (dk == 1) st = 3;
      else if (dk == 2) begin st = 2; sy = (acc == 2) ? 32'h0600_0000 : 32'h0400_0000; end
      else if (dk == 4) begin st = 2; sy = (acc == 2) ? 32'h0610_0000 : 32'h0410_0000; end
      else if (dk == 0 && acc == 2 && !k) prot = 1;
      else begin ra = ea; pm = k ? 3'b011 : 3'b001; end
    end else if (s[28] && acc == 0) begin st = 1; sy = 32'h1000_0000; end
    else begin
      walk = 1;
      if (!wf) begin st = (acc == 0) ? 1 : 2; sy = (acc == 2) ? 32'h4200_0000 : 32'h4000_0000; end
      else begin
        case (pp)
          0: p = k ? 3'b000 : 3'b111;
          1: p = k ? 3'b101 : 3'b111;
          2: p = 3'b111;
          default: p = 3'b101;
        endcase
        if (s[28]) p[2] = 0;
        ok = (acc == 0) ? p[2] : (acc == 2) ? p[1] : p[0];
        if (ok) begin ra = {rpn, ea[11:0]}; pm = p; end else prot = 1;
      end
    end
    if (prot) begin st = (acc == 0) ? 1 : 2; sy = (acc == 2) ? 32'h0A00_0000 : 32'h0800_0000; end
    fa = (st == 2 || st == 3) ? ea : 0;
  endtask

  task automatic run(string rq, logic [31:0] ea, logic [1:0] acc, logic [2:0] dk, bit rl, bit us,
                     bit bh, logic [31:0] bra, logic [2:0] bpm, bit wf, logic [19:0] rpn,
                     logic [1:0] pp, int lb, int lw);
    bit walk;
    logic [1:0] st;
    logic [31:0] ra, sy, fa;
    logic [2:0] pm;
    model(ea, acc, dk, rl, us, bh, bra, bpm, wf, rpn, pp, walk, st, ra, pm, sy, fa);
    @(negedge clk);
    chk(rq, "req_ready idle", {31'd0, req_ready}, 1);
    req_valid = 1; req_ea = ea; req_acc = acc; req_kind = dk; req_real = rl; req_user = us;
    @(negedge clk);
    req_valid = 0;
    if (!rl) begin
      for (int i = 0; i < lb; i++) begin
        chk(rq, "bat_req_valid", {31'd0, bat_req_valid}, 1);
        chk(rq, "rsp_valid early", {31'd0, rsp_valid}, 0);
        if (i == 0) begin
          chk(rq, "bat_ea", bat_ea, ea);
          chk(rq, "bat_fetch/user", {30'd0, bat_fetch, bat_user}, {30'd0, acc == 0, us});
        end
        if (i == lb - 1) begin
          bat_rsp_valid = 1; bat_hit = bh; bat_raddr = bra; bat_perm = bpm;
        end
        @(negedge clk);
        bat_rsp_valid = 0;
      end
      if (walk) begin
        for (int i = 0; i < lw; i++) begin
          chk(rq, "walk_req_valid", {31'd0, walk_req_valid}, 1);
          chk(rq, "rsp_valid early", {31'd0, rsp_valid}, 0);
          if (i == 0) begin
            chk(rq, "walk_ea", walk_ea, ea);
            chk(rq, "walk_vsid", {8'd0, walk_vsid}, {8'd0, sr_m[ea[31:28]][23:0]});
          end
          if (i == lw - 1) begin
            walk_rsp_valid = 1; walk_found = wf; walk_rpn = rpn; walk_pp = pp;
          end
          @(negedge clk);
          walk_rsp_valid = 0;
        end
      end else begin
        chk(rq, "no walk", {31'd0, walk_req_valid}, 0);
      end
    end else begin
      chk(rq, "no matcher", {31'd0, bat_req_valid}, 0);
    end
    for (int h = 0; h < 2; h++) begin
      chk(rq, "rsp_valid", {31'd0, rsp_valid}, 1);
      chk(rq, "status", {30'd0, rsp_status}, {30'd0, st});
      chk(rq, "raddr", rsp_raddr, ra);
      chk(rq, "perm", {29'd0, rsp_perm}, {29'd0, pm});
      chk(rq, "syndrome", rsp_syndrome, sy);
      chk(rq, "fault_addr", rsp_fault_addr, fa);
      if (h == 0) @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(rq, "rsp drop", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) sr_m[i] = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset req_ready", {31'd0, req_ready}, 1);
    chk("R11", "reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R2", "reset bat_req", {31'd0, bat_req_valid}, 0);
    rst_n = 1;
    // R3 segment layout: [31] direct-store [30] sup key [29] user key [28] no-exec [23:0] id
    wr_sr(0, 32'h200A_BCDE);
    wr_sr(1, 32'hA000_0000);
    wr_sr(2, 32'h1000_5555);
    wr_sr(3, 32'hE000_0000);
    wr_sr(7, 32'h6012_3456);
    // R1 real mode
    run("R1", 32'h1234_5678, 2'd2, 3'd0, 1, 1, 1, 32'hFFFF_0000, 3'b000, 0, 0, 0, 1, 1);
    // R2 block translation
    run("R2", 32'h0000_1040, 2'd1, 3'd0, 0, 0, 1, 32'h8000_1040, 3'b001, 0, 0, 0, 2, 1);
    run("R2", 32'h0000_2000, 2'd2, 3'd0, 0, 0, 1, 32'h8000_2000, 3'b001, 0, 0, 0, 1, 1);
    run("R2", 32'h0000_3000, 2'd0, 3'd0, 0, 0, 1, 32'h8000_3000, 3'b011, 0, 0, 0, 3, 1);
    // R4 fetch from direct-store and no-exec segments
    run("R4", 32'h1000_0100, 2'd0, 3'd0, 0, 0, 0, 0, 0, 1, 20'h1, 2'd2, 1, 1);
    run("R4", 32'h2000_0100, 2'd0, 3'd0, 0, 0, 0, 0, 0, 1, 20'h1, 2'd2, 2, 1);
    // R5 walk misses
    run("R5", 32'h0123_4567, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    run("R5", 32'h0123_4567, 2'd2, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R5", 32'h0123_4567, 2'd0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 3);
    // R7 real address composition, R6 key/pp table
    run("R7", 32'h0ABC_D123, 2'd2, 3'd0, 0, 0, 0, 0, 0, 1, 20'h5A5A5, 2'd2, 1, 1);
    run("R6", 32'h0000_0444, 2'd1, 3'd0, 0, 1, 0, 0, 0, 1, 20'h00111, 2'd0, 1, 1);
    run("R6", 32'h0000_0444, 2'd1, 3'd0, 0, 0, 0, 0, 0, 1, 20'h00111, 2'd0, 1, 1);
    run("R6", 32'h0000_0888, 2'd2, 3'd0, 0, 0, 0, 0, 0, 1, 20'h00222, 2'd3, 1, 2);
    run("R6", 32'h0000_0888, 2'd0, 3'd0, 0, 1, 0, 0, 0, 1, 20'h00333, 2'd1, 1, 1);
    run("R6", 32'h0000_0888, 2'd2, 3'd0, 0, 1, 0, 0, 0, 1, 20'h00333, 2'd1, 1, 1);
    run("R6", 32'h7000_0010, 2'd1, 3'd0, 0, 0, 0, 0, 0, 1, 20'hCAFE0, 2'd1, 1, 1);
    run("R6", 32'h2000_0ABC, 2'd1, 3'd0, 0, 0, 0, 0, 0, 1, 20'h44444, 2'd2, 1, 1);
    // R8/R9 direct-store path
    run("R9", 32'h1000_0200, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R9", 32'h1000_0204, 2'd2, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R9", 32'h1000_0208, 2'd2, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R9", 32'h3000_0208, 2'd2, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1);
    run("R8", 32'h1000_0300, 2'd2, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R10", 32'h1000_0304, 2'd1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R8", 32'h1000_0308, 2'd2, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R8", 32'h1000_030C, 2'd1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R8", 32'h1000_0310, 2'd2, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R8", 32'h1000_0314, 2'd1, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 3, 1);
    // R3 register rewrite takes effect; R12 encodings covered by every status check
    wr_sr(0, 32'h9000_0000);
    run("R3", 32'h0000_0500, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R12", 32'h0000_0504, 2'd0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule